// File: doc/BRIEF.md
# I2C Register Target with Persistent Command Pointer

This block is the serial front end of a small parallel-port expander. It watches an I2C/SMBus bus through a system clock and picks out START, repeated START and STOP. It answers to one 7-bit address. The upper four bits of that address are fixed at `0011`, and the lower three come from strap pins. Its only drive on the bus is an open-drain enable that pulls SDA low. It never stretches the clock.

After the address, the first byte of a write is a command byte. Its two low bits become a register pointer that selects one of four registers. Every byte after it is handed to the register side as a one-cycle write strobe with its data. A read returns the register that the stored pointer selects. Each byte sent is a fresh sample taken through a one-cycle read strobe.

The pointer stays in place between transactions. A master can therefore set it once and then issue bare read transactions, with no command byte, to stream the same register.

The register interface has no back-pressure, because the bus cannot be held off. The consumer must take every write strobe in the cycle it is high. Read data must be valid in the cycle the read strobe is high, and it is captured at the clock edge that ends that cycle.

Top module: `i2c_cmd_target`

## Requirements
- R1: An address byte whose upper seven bits equal `0011` followed by `strap_addr[2:1:0]` (MSB first) is acknowledged by `sda_oe` high through the ninth clock. Its last bit selects the direction: 1 means read and 0 means write.
- R2: An address byte that does not match gets no acknowledge. Every later byte up to the next START is then ignored: no acknowledge, no strobe, and no change of `reg_sel`.
- R3: In a write, the first byte after the address is acknowledged. Its bits [1:0] replace the pointer shown on `reg_sel`, and its bits [7:2] are discarded.
- R4: Each byte after the command byte in a write is acknowledged. It is presented as a single-cycle `wr_stb` with the byte on `wr_data` and the pointer on `reg_sel`.
- R5: In a read, `rd_stb` pulses for one cycle before each byte. The byte presented on `rd_data` during that cycle is then shifted out MSB first, so consecutive bytes are separate samples.
- R6: The pointer keeps its value across STOP and START. A read-only transaction uses the pointer last written.
- R7: A repeated START at any point returns the block to address reception. A write of address plus command, followed by a repeated START and a read address, reads the newly selected register.
- R8: After a read byte that the master does not acknowledge, SDA is released. No further `rd_stb` occurs until a new START.
- R9: A STOP at any point, including in the middle of a byte, releases SDA and abandons the transfer without a write strobe. The next transaction is served normally.
- R10: Reset (`rst_n` low) releases SDA, returns the protocol to idle and clears the pointer to 0, even in the middle of a transfer.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_addr | input | 3 | Low three bits of the target address |
| reg_sel | output | 2 | Stored register pointer |
| wr_stb | output | 1 | One-cycle write strobe for the selected register |
| wr_data | output | 8 | Byte to write, valid while `wr_stb` is high |
| rd_stb | output | 1 | One-cycle read request for the selected register |
| rd_data | input | 8 | Register value, valid during the `rd_stb` cycle |

## Verification
The situations that are hardest to reach from the ports are transfers that are cut short. These are a STOP that arrives after only a few bits of a data byte, a reset while the target is in the middle of a write, and a repeated START between the command byte and the read address. The bench's master tasks build each of these from bit-level pieces: start, single bit cycle, stop, and a reset pulse.

After each interruption, a bare read transaction shows through the bus which pointer survived. A reference model keeps the expected pointer, the queue of expected writes and the queue of expected read samples. On every clock it compares the strobes, `reg_sel` and the timing of the SDA enable against that model.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;

  // Protocol phases of the target engine
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // not addressed, waits for START
    ST_ADDR  = 3'd1,  // shifting in the address byte
    ST_CMD   = 3'd2,  // shifting in the command byte
    ST_WDATA = 3'd3,  // shifting in write data bytes
    ST_ACK   = 3'd4,  // holding SDA low for the acknowledge clock
    ST_RDATA = 3'd5,  // shifting a register sample out
    ST_MACK  = 3'd6   // reading the master's acknowledge
  } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int              WIDTH     = 2,
  parameter int              STAGES    = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  // Stage 0 takes the raw pins, the last stage is the settled value
  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/i2c_bus_events.sv
`timescale 1ns/1ps
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);

  logic scl_q, sda_q;

  // Idle bus is high on both lines
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // Data moving while the clock stays high marks a frame boundary
  assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
  assign sda_bit   =  sda_s;

endmodule

// File: rtl/i2c_tgt_fsm.sv
`timescale 1ns/1ps
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 3,
  parameter logic [ADDR_W-STRAP_W-1:0] FIXED_BITS = 4'b0011,
  parameter int PTR_W   = 2,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic               sda_bit,
  input  logic [STRAP_W-1:0] strap,
  input  logic [DATA_W-1:0]  rd_data,
  output logic               sda_oe,
  output logic [PTR_W-1:0]   reg_sel,
  output logic               wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic               rd_stb
);

  localparam int                CNT_W    = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]  LAST_BIT = CNT_W'(DATA_W);

  tgt_state_e         state, after_ack;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  rx_sh, tx_sh;
  logic [PTR_W-1:0]   ptr;
  logic               oe, wr_q, rd_q, mack;
  logic [DATA_W-1:0]  wdat;
  logic [ADDR_W-1:0]  own_addr;

  assign own_addr = {FIXED_BITS, strap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_ack <= ST_IDLE;
      bit_cnt   <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      ptr       <= '0;
      oe        <= 1'b0;
      wr_q      <= 1'b0;
      rd_q      <= 1'b0;
      mack      <= 1'b0;
      wdat      <= '0;
    end else begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
      if (start_det) begin
        state   <= ST_ADDR;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise) begin
              rx_sh   <= {rx_sh[DATA_W-2:0], sda_bit};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == LAST_BIT) begin
              bit_cnt <= '0;
              case (state)
                ST_ADDR: begin
                  if (rx_sh[DATA_W-1:1] == own_addr) begin
                    oe        <= 1'b1;
                    state     <= ST_ACK;
                    after_ack <= rx_sh[0] ? ST_RDATA : ST_CMD;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                ST_CMD: begin
                  ptr       <= rx_sh[PTR_W-1:0];
                  oe        <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end
                default: begin
                  wr_q      <= 1'b1;
                  wdat      <= rx_sh;
                  oe        <= 1'b1;
                  state     <= ST_ACK;
                  after_ack <= ST_WDATA;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              oe      <= 1'b0;
              state   <= after_ack;
              bit_cnt <= '0;
              if (after_ack == ST_RDATA) rd_q <= 1'b1;
            end
          end
          ST_RDATA: begin
            if (rd_q) begin
              // Sample arrives in the strobe cycle; first bit goes out now
              tx_sh <= rd_data;
              oe    <= ~rd_data[DATA_W-1];
            end else if (scl_rise) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall) begin
              if (bit_cnt == LAST_BIT) begin
                oe      <= 1'b0;
                state   <= ST_MACK;
                bit_cnt <= '0;
              end else begin
                oe    <= ~tx_sh[DATA_W-2];
                tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_bit;
            end else if (scl_fall) begin
              if (mack) begin
                state <= ST_RDATA;
                rd_q  <= 1'b1;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe  = oe;
  assign reg_sel = ptr;
  assign wr_stb  = wr_q;
  assign wr_data = wdat;
  assign rd_stb  = rd_q;

endmodule

// File: rtl/i2c_cmd_target.sv
`timescale 1ns/1ps
module i2c_cmd_target #(
  parameter int STRAP_W     = 3,
  parameter int ADDR_W      = 7,
  parameter logic [ADDR_W-STRAP_W-1:0] FIXED_BITS = 4'b0011,
  parameter int PTR_W       = 2,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap_addr,
  output logic [PTR_W-1:0]   reg_sel,
  output logic               wr_stb,
  output logic [DATA_W-1:0]  wr_data,
  output logic               rd_stb,
  input  logic [DATA_W-1:0]  rd_data
);

  logic [1:0] lines_s;
  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;

  i2c_line_sync #(
    .WIDTH    (2),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(2'b11)
  ) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({scl_in, sda_in}),
    .dout (lines_s)
  );

  i2c_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_s    (lines_s[1]),
    .sda_s    (lines_s[0]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_bit  (sda_bit)
  );

  i2c_tgt_fsm #(
    .ADDR_W    (ADDR_W),
    .STRAP_W   (STRAP_W),
    .FIXED_BITS(FIXED_BITS),
    .PTR_W     (PTR_W),
    .DATA_W    (DATA_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .sda_bit  (sda_bit),
    .strap    (strap_addr),
    .rd_data  (rd_data),
    .sda_oe   (sda_oe),
    .reg_sel  (reg_sel),
    .wr_stb   (wr_stb),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb)
  );

endmodule

// File: rtl/i2c_cmd_target_chk.sv
`timescale 1ns/1ps
module i2c_cmd_target_chk #(
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_in,
  input logic             sda_oe,
  input logic [PTR_W-1:0] reg_sel,
  input logic             wr_stb,
  input logic             rd_stb
);

  // R11: the SDA enable only moves while the bus clock is low
  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_in);

  // R3: the pointer is only replaced during a low clock phase
  assert_sel_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(reg_sel) |-> !scl_in);

  // R4: one strobe per received byte
  assert_wr_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  // R4: a write and a read request never share a cycle
  assert_strobe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  // R5: one read request per transmitted byte
  assert_rd_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  // R8: a new sample is only fetched after a clock falling edge
  assert_rd_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |-> !scl_in);

endmodule

bind i2c_cmd_target i2c_cmd_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .scl_in (scl_in),
  .sda_oe (sda_oe),
  .reg_sel(reg_sel),
  .wr_stb (wr_stb),
  .rd_stb (rd_stb)
);

// File: tb/i2c_cmd_target_bench.sv
`timescale 1ns/1ps
module i2c_cmd_target_bench;

  localparam int Q = 5;  // clocks per quarter of a bus bit

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       scl   = 1'b1;
  logic       m_sda = 1'b1;
  logic [2:0] strap = 3'b101;
  wire        sda_oe;
  wire        bus_sda = m_sda & ~sda_oe;
  wire  [1:0] reg_sel;
  wire        wr_stb, rd_stb;
  wire  [7:0] wr_data;
  logic [5:0] samp = '0;
  wire  [7:0] rd_data = {reg_sel, samp};

  i2c_cmd_target u_i2c_cmd_target (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl),
    .sda_in    (bus_sda),
    .sda_oe    (sda_oe),
    .strap_addr(strap),
    .reg_sel   (reg_sel),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .rd_stb    (rd_stb),
    .rd_data   (rd_data)
  );

  // Reference model state
  int         vecs = 0;
  int         errs = 0;
  logic [1:0] model_ptr = 2'd0;
  logic [9:0] exp_wr[$];
  logic [7:0] exp_rd[$];
  bit         cmp_ptr = 0;
  bit         rd_allowed = 0;
  int         rd_count = 0;
  logic       prev_oe = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Each requested sample is a fresh value from the selected register
  always @(posedge clk) begin
    if (rd_stb) begin
      exp_rd.push_back({model_ptr, samp});
      samp <= samp + 6'd1;
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!((sda_oe !== prev_oe) && scl), "R11 enable moved with SCL high", sda_oe, prev_oe);
      if (cmp_ptr) chk(reg_sel === model_ptr, "R6 pointer", reg_sel, model_ptr);
      if (wr_stb) begin
        if (exp_wr.size() == 0) chk(0, "R2 R9 stray write", {reg_sel, wr_data}, 0);
        else begin
          logic [9:0] e;
          e = exp_wr.pop_front();
          chk({reg_sel, wr_data} === e, "R4 write strobe", {reg_sel, wr_data}, e);
        end
      end
      if (rd_stb) begin
        rd_count++;
        chk(rd_allowed, "R8 read strobe outside a read", 1, 0);
        chk(reg_sel === model_ptr, "R6 read pointer", reg_sel, model_ptr);
      end
    end
    prev_oe = sda_oe;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cyc(input bit b, output bit s);
    tick(Q); m_sda = b;
    tick(Q); scl = 1'b1;
    tick(Q); s = bus_sda;
    tick(Q); scl = 1'b0;
  endtask

  task automatic do_start;
    tick(Q); m_sda = 1'b1;
    tick(Q); scl = 1'b1;
    tick(Q); m_sda = 1'b0;
    tick(Q); scl = 1'b0;
  endtask

  task automatic do_stop;
    tick(Q); m_sda = 1'b0;
    tick(Q); scl = 1'b1;
    tick(Q); m_sda = 1'b1;
    tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string req);
    bit s;
    for (int i = 7; i >= 0; i--) bit_cyc(b[i], s);
    bit_cyc(1'b1, s);
    chk((s == 1'b0) == exp_ack, req, !s, exp_ack);
  endtask

  task automatic recv_byte(input bit last, input string req);
    bit s;
    logic [7:0] got, e;
    for (int i = 7; i >= 0; i--) begin
      bit_cyc(1'b1, s);
      got[i] = s;
    end
    bit_cyc(last, s);
    if (exp_rd.size() == 0) chk(0, req, got, 0);
    else begin
      e = exp_rd.pop_front();
      chk(got === e, req, got, e);
    end
  endtask

  task automatic set_ptr(input logic [7:0] cmd, input string req);
    cmp_ptr = 0;
    send_byte(cmd, 1'b1, req);
    model_ptr = cmd[1:0];
    cmp_ptr = 1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R1..all actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    bit s;
    tick(6);
    rst_n = 1'b1;
    tick(4);
    chk(sda_oe == 1'b0, "R10 enable after reset", sda_oe, 0);
    chk(reg_sel == 2'd0, "R10 pointer after reset", reg_sel, 0);
    cmp_ptr = 1;

    // Write with junk upper command bits, two data bytes
    do_start();
    send_byte(8'h3A, 1'b1, "R1 write address ack");
    set_ptr(8'hFD, "R3 command ack");
    exp_wr.push_back({2'd1, 8'hA5});
    send_byte(8'hA5, 1'b1, "R4 data ack");
    exp_wr.push_back({2'd1, 8'h3C});
    send_byte(8'h3C, 1'b1, "R4 data ack");
    do_stop();
    tick(4);
    chk(exp_wr.size() == 0, "R4 all writes delivered", exp_wr.size(), 0);
    chk(reg_sel == 2'd1, "R3 low bits kept", reg_sel, 1);

    // Bare read: pointer from the earlier write, three fresh samples
    rd_count = 0; rd_allowed = 1;
    do_start();
    send_byte(8'h3B, 1'b1, "R1 read address ack");
    recv_byte(1'b0, "R5 read byte 0");
    recv_byte(1'b0, "R5 read byte 1");
    recv_byte(1'b1, "R6 read byte 2");
    rd_allowed = 0;
    tick(4 * Q);
    chk(rd_count == 3, "R8 strobes stop at not-acknowledge", rd_count, 3);
    chk(sda_oe == 1'b0, "R8 SDA released", sda_oe, 0);
    do_stop();

    // Combined transfer through a repeated START
    do_start();
    send_byte(8'h3A, 1'b1, "R1 write address ack");
    set_ptr(8'h02, "R3 command ack");
    rd_count = 0; rd_allowed = 1;
    do_start();
    send_byte(8'h3B, 1'b1, "R7 address after repeated start");
    recv_byte(1'b0, "R7 read byte 0");
    recv_byte(1'b1, "R7 read byte 1");
    rd_allowed = 0;
    do_stop();
    chk(rd_count == 2, "R7 strobe count", rd_count, 2);

    // Addresses that do not match
    do_start();
    send_byte(8'h38, 1'b0, "R2 wrong strap not acknowledged");
    send_byte(8'h01, 1'b0, "R2 following byte ignored");
    send_byte(8'h55, 1'b0, "R2 following byte ignored");
    do_stop();
    do_start();
    send_byte(8'h5A, 1'b0, "R2 wrong fixed bits not acknowledged");
    do_stop();
    chk(reg_sel == 2'd2, "R2 pointer untouched", reg_sel, 2);

    // STOP in the middle of a data byte
    do_start();
    send_byte(8'h3A, 1'b1, "R1 write address ack");
    set_ptr(8'h03, "R3 command ack");
    bit_cyc(1'b1, s);
    bit_cyc(1'b0, s);
    bit_cyc(1'b1, s);
    do_stop();
    tick(4);
    chk(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
    rd_count = 0; rd_allowed = 1;
    do_start();
    send_byte(8'h3B, 1'b1, "R9 recovery after stop");
    recv_byte(1'b1, "R9 read after aborted write");
    rd_allowed = 0;
    do_stop();

    // Reset during a write
    do_start();
    send_byte(8'h3A, 1'b1, "R1 write address ack");
    set_ptr(8'h01, "R3 command ack");
    bit_cyc(1'b0, s);
    bit_cyc(1'b0, s);
    rst_n = 1'b0;
    model_ptr = 2'd0;
    tick(2);
    chk(reg_sel == 2'd0, "R10 pointer cleared mid transfer", reg_sel, 0);
    chk(sda_oe == 1'b0, "R10 enable cleared mid transfer", sda_oe, 0);
    m_sda = 1'b1;
    tick(Q);
    scl = 1'b1;
    tick(Q);
    rst_n = 1'b1;
    tick(Q);
    rd_allowed = 1;
    do_start();
    send_byte(8'h3B, 1'b1, "R10 served after reset");
    recv_byte(1'b1, "R10 read uses cleared pointer");
    rd_allowed = 0;
    do_stop();

    tick(20);
    chk(exp_rd.size() == 0, "R5 every sample consumed", exp_rd.size(), 0);
    chk(exp_wr.size() == 0, "R4 no pending write", exp_wr.size(), 0);
    finish_run();
  end

endmodule